// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This unit sits between a 32-bit register datapath and a byte-addressed synchronous data memory. For each accepted request it adds a sign-extended 16-bit offset to a base register value to form the effective address. It checks that word accesses fall on a four-byte boundary and drives the memory port in the same cycle. Store data goes out on the proper byte lanes with a byte-enable mask. Load data is picked out of the returned word and, for byte loads, sign-extended for the register writeback.

Requests arrive on a valid/ready port. Every accepted request, including stores and unknown opcodes, yields exactly one response on a valid/ready writeback port one cycle later, carrying the load result and a misalignment flag. Back-pressure works as follows. The unit holds a single response slot, so `req_ready` is high only when that slot is empty or is draining in the current cycle (`wb_ready` high). While `wb_valid` is high and `wb_ready` is low, the response holds steady and no new request is accepted. The memory is only required to present read data in the cycle right after a read; the unit keeps its own copy when the response stalls.

Top module: `lsu_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` carries that address with its two low bits cleared, in the same cycle the request is accepted.
- R2: A word load (opcode 35) or word store (opcode 43) whose effective address is not a multiple of 4 drives `mem_we` and `mem_re` low. Its response has `wb_misalign` = 1 and `wb_data` = 0, and memory is left unchanged.
- R3: A byte load (opcode 32) or byte store (opcode 40) never sets `wb_misalign`, whatever the address; non-word responses never set it either.
- R4: An aligned word store drives `mem_we` = 1, `mem_be` = 4'b1111 and `mem_wdata` = `req_wdata`.
- R5: A byte store drives `mem_we` = 1 and a one-hot `mem_be`, with byte offset k (address bits 1:0) selecting `mem_be[3-k]`. `req_wdata[7:0]` is repeated on all four lanes. Only the addressed byte of memory changes.
- R6: A byte load returns the byte at offset k, taken from read-data bits [31-8k:24-8k] (big-endian lanes). It appears in `wb_data[7:0]` with bits 31:8 copied from its bit 7.
- R7: An aligned word load drives `mem_re` = 1 and returns the whole read word in `wb_data`.
- R8: Each accepted request gives `wb_valid` = 1 in the next cycle. Store responses carry `wb_data` = 0.
- R9: `req_ready` = !`wb_valid` || `wb_ready`. While `wb_valid` is high and `wb_ready` is low, `wb_data` and `wb_misalign` stay constant, even if memory read data changes.
- R10: Any other opcode drives no memory enables and gives a response with `wb_data` = 0 and `wb_misalign` = 0.
- R11: After reset, `wb_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 6 | Operation code (35, 43, 32, 40) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed offset |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, valid the cycle after mem_re |
| wb_valid | output | 1 | Response present |
| wb_ready | input | 1 | Response taken when high with wb_valid |
| wb_data | output | 32 | Load result (0 for stores) |
| wb_misalign | output | 1 | Word access was not 4-byte aligned |

## Verification
Word and byte operations are driven with random bases and random signed offsets, so each lane and both signs of the offset occur. This separates a correct sign extension of the offset from a zero extension, and a big-endian lane choice from a reversed one. Byte loads of values with bit 7 set and clear separate sign extension from zero fill. Misaligned word stores are followed by aligned reloads, which shows that the write was really suppressed. Random response stalls, with memory read data scrambled during the stall, show whether the result is held by the unit or wrongly taken from the live memory bus.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_LD_WORD = 6'd35;
  localparam logic [OPC_W-1:0] OPC_ST_WORD = 6'd43;
  localparam logic [OPC_W-1:0] OPC_LD_BYTE = 6'd32;
  localparam logic [OPC_W-1:0] OPC_ST_BYTE = 6'd40;

  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_LOAD_W  = 3'd1,
    K_LOAD_B  = 3'd2,
    K_STORE_W = 3'd3,
    K_STORE_B = 3'd4
  } kind_e;

  function automatic kind_e decode_op(input logic [OPC_W-1:0] opc);
    kind_e k;
    case (opc)
      OPC_LD_WORD: k = K_LOAD_W;
      OPC_ST_WORD: k = K_STORE_W;
      OPC_LD_BYTE: k = K_LOAD_B;
      OPC_ST_BYTE: k = K_STORE_B;
      default:     k = K_NONE;
    endcase
    return k;
  endfunction

  function automatic logic is_word(input kind_e k);
    return (k == K_LOAD_W) || (k == K_STORE_W);
  endfunction

  function automatic logic is_load(input kind_e k);
    return (k == K_LOAD_W) || (k == K_LOAD_B);
  endfunction

  function automatic logic is_store(input kind_e k);
    return (k == K_STORE_W) || (k == K_STORE_B);
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [DATA_W-1:0]          base,
  input  logic [OFF_W-1:0]           offset,
  input  kind_e                      kind,
  output logic [DATA_W-1:0]          word_addr,
  output logic [$clog2(DATA_W/8)-1:0] lane,
  output logic                       misalign
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int EXT_W  = DATA_W - OFF_W;

  logic [DATA_W-1:0] off_ext;
  logic [DATA_W-1:0] eff;

  // Offset is two's complement; widen by replicating its top bit.
  assign off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign eff       = base + off_ext;
  assign lane      = eff[LANE_W-1:0];
  assign word_addr = {eff[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
  // Only whole-word accesses carry an alignment rule.
  assign misalign  = is_word(kind) && (lane != '0);
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        en,
  input  kind_e                       kind,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [DATA_W-1:0]           src,
  output logic                        we,
  output logic [DATA_W/8-1:0]         be,
  output logic [DATA_W-1:0]           wdata
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  assign we = en && is_store(kind);

  // Big-endian lanes: byte offset g lives in the most significant slot
  // counted from the top, and its enable is bit LANES-1-g.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[LANES-1-g] = en && ((kind == K_STORE_W) ||
                                  ((kind == K_STORE_B) && (lane == LANE_W'(g))));
    assign wdata[DATA_W-1-8*g -: 8] = (kind == K_STORE_B) ? src[7:0]
                                                          : src[DATA_W-1-8*g -: 8];
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32
) (
  input  logic                        byte_mode,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [DATA_W-1:0]           word,
  output logic [DATA_W-1:0]           result
);
  localparam int LANES = DATA_W / 8;

  logic [7:0] lane_byte [LANES];
  logic [7:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_pick
    assign lane_byte[g] = word[DATA_W-1-8*g -: 8];
  end

  assign picked = lane_byte[lane];
  assign result = byte_mode ? {{(DATA_W-8){picked[7]}}, picked} : word;
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [OPC_W-1:0]    req_op,
  input  logic [DATA_W-1:0]   req_base,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   mem_addr,
  output logic                mem_re,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                wb_valid,
  input  logic                wb_ready,
  output logic [DATA_W-1:0]   wb_data,
  output logic                wb_misalign
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  kind_e             req_kind;
  logic [LANE_W-1:0] req_lane;
  logic              req_mis;
  logic              fire;
  logic              go;

  // Response slot state.
  logic              s_valid;
  logic              s_fresh;
  kind_e             s_kind;
  logic [LANE_W-1:0] s_lane;
  logic              s_mis;
  logic [DATA_W-1:0] s_hold;
  logic [DATA_W-1:0] ext_data;
  logic [DATA_W-1:0] live_data;

  assign req_kind  = decode_op(req_op);
  assign req_ready = !s_valid || wb_ready;
  assign fire      = req_valid && req_ready;
  assign go        = fire && !req_mis;

  lsu_addr_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_addr (
    .base      (req_base),
    .offset    (req_offset),
    .kind      (req_kind),
    .word_addr (mem_addr),
    .lane      (req_lane),
    .misalign  (req_mis)
  );

  lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .en    (go),
    .kind  (req_kind),
    .lane  (req_lane),
    .src   (req_wdata),
    .we    (mem_we),
    .be    (mem_be),
    .wdata (mem_wdata)
  );

  assign mem_re = go && is_load(req_kind);

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .byte_mode (s_kind == K_LOAD_B),
    .lane      (s_lane),
    .word      (mem_rdata),
    .result    (ext_data)
  );

  assign live_data   = (is_load(s_kind) && !s_mis) ? ext_data : '0;
  assign wb_valid    = s_valid;
  assign wb_data     = s_fresh ? live_data : s_hold;
  assign wb_misalign = s_valid && s_mis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_fresh <= 1'b0;
      s_kind  <= K_NONE;
      s_lane  <= '0;
      s_mis   <= 1'b0;
      s_hold  <= '0;
    end else begin
      if (fire) begin
        s_valid <= 1'b1;
        s_fresh <= 1'b1;
        s_kind  <= req_kind;
        s_lane  <= req_lane;
        s_mis   <= req_mis;
      end else if (wb_ready) begin
        s_valid <= 1'b0;
        s_fresh <= 1'b0;
      end else if (s_valid) begin
        // Stalled: memory data is only good for one cycle, keep a copy.
        s_hold  <= wb_data;
        s_fresh <= 1'b0;
      end
    end
  end

  // R8: a response follows every acceptance.
  p_resp_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> wb_valid);

  // R9: stalled response is frozen and no new request enters.
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_misalign)));

  p_no_accept_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |-> !req_ready);

  // R2: a misaligned word access touches no memory enable.
  p_misalign_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mis) |-> (!mem_we && !mem_re && (mem_be == '0)));

  // R3: only word kinds may flag misalignment.
  p_flag_word_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_misalign |-> ((s_kind == K_LOAD_W) || (s_kind == K_STORE_W)));

  // R5 / R4: write mask is either full or a single lane.
  p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (($countones(mem_be) == 1) || (mem_be == '1)));

  // R6: byte load result is sign-filled above bit 7.
  p_sext_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && (s_kind == K_LOAD_B)) |-> (wb_data[DATA_W-1:8] == {(DATA_W-8){wb_data[7]}}));
endmodule

// File: tb/lsu_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_addr;
  logic        mem_re;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        wb_valid;
  logic        wb_ready = 1'b1;
  logic [31:0] wb_data;
  logic        wb_misalign;

  int checks = 0;
  int errors = 0;

  logic [7:0] ram [256];
  logic [7:0] shadow [256];

  always #2 clk = ~clk;

  lsu_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .wb_misalign(wb_misalign)
  );

  // Synchronous byte memory (aliased on 8 address bits); garbage when idle.
  always @(posedge clk) begin
    if (mem_we) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[3-k]) ram[{mem_addr[7:2], 2'(k)}] <= mem_wdata[31-8*k -: 8];
    end
    if (mem_re)
      mem_rdata <= {ram[{mem_addr[7:2], 2'd0}], ram[{mem_addr[7:2], 2'd1}],
                    ram[{mem_addr[7:2], 2'd2}], ram[{mem_addr[7:2], 2'd3}]};
    else
      mem_rdata <= $urandom;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] shadow_word(input logic [31:0] a);
    return {shadow[{a[7:2], 2'd0}], shadow[{a[7:2], 2'd1}],
            shadow[{a[7:2], 2'd2}], shadow[{a[7:2], 2'd3}]};
  endfunction

  task automatic do_op(input logic [5:0] opc, input logic [31:0] base,
                       input logic [15:0] off, input logic [31:0] wd, input int hold);
    logic [31:0] ea, e_addr, e_wdata, e_data;
    logic [3:0]  e_be;
    logic        wl, ws, bl, bs, mis, e_re, e_we;
    logic [1:0]  ln;
    logic [7:0]  b;
    ea = base + {{16{off[15]}}, off};
    ln = ea[1:0];
    e_addr = {ea[31:2], 2'b00};
    wl = (opc == 6'd35); ws = (opc == 6'd43);
    bl = (opc == 6'd32); bs = (opc == 6'd40);
    mis = (wl || ws) && (ln != 2'd0);
    e_re = (wl || bl) && !mis;
    e_we = (ws || bs) && !mis;
    e_be = 4'b0000;
    e_wdata = wd;
    e_data = 32'd0;
    if (ws && !mis) e_be = 4'b1111;
    if (bs) begin e_be = 4'b1000 >> ln; e_wdata = {4{wd[7:0]}}; end
    if (wl && !mis) e_data = shadow_word(ea);
    if (bl) begin
      b = shadow[ea[7:0]];
      e_data = {{24{b[7]}}, b};
    end
    if (ws && !mis)
      for (int k = 0; k < 4; k++) shadow[{ea[7:2], 2'(k)}] = wd[31-8*k -: 8];
    if (bs) shadow[ea[7:0]] = wd[7:0];

    @(negedge clk);
    req_op = opc; req_base = base; req_offset = off; req_wdata = wd;
    req_valid = 1'b1;
    wb_ready = (hold == 0);
    #1;
    chk(req_ready, "R9 ready when slot empty", 32'(req_ready), 32'd1);
    chk(mem_addr == e_addr, "R1 mem_addr", mem_addr, e_addr);
    chk(mem_re == e_re, (mis ? "R2 mem_re" : (opc == 6'd35 ? "R7 mem_re" : "R10 mem_re")),
        32'(mem_re), 32'(e_re));
    chk(mem_we == e_we, (mis ? "R2 mem_we" : (bs ? "R5 mem_we" : (ws ? "R4 mem_we" : "R10 mem_we"))),
        32'(mem_we), 32'(e_we));
    chk(mem_be == e_be, (bs ? "R5 mem_be" : "R4 mem_be"), 32'(mem_be), 32'(e_be));
    if (e_we) chk(mem_wdata == e_wdata, (bs ? "R5 mem_wdata" : "R4 mem_wdata"), mem_wdata, e_wdata);

    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(wb_valid, "R8 response valid", 32'(wb_valid), 32'd1);
    chk(wb_data == e_data, (bl ? "R6 byte load" : (wl ? (mis ? "R2 data" : "R7 word load") : "R8 store/other data")),
        wb_data, e_data);
    chk(wb_misalign == mis, (mis ? "R2 flag" : "R3 flag"), 32'(wb_misalign), 32'(mis));
    for (int i = 0; i < hold; i++) begin
      chk(!req_ready, "R9 ready low while stalled", 32'(req_ready), 32'd0);
      @(negedge clk);
      #1;
      chk(wb_valid && wb_data == e_data && wb_misalign == mis, "R9 held response", wb_data, e_data);
    end
    wb_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(!wb_valid, "R8 single response", 32'(wb_valid), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'($urandom);
      shadow[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chk(!wb_valid, "R11 wb_valid in reset", 32'(wb_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!wb_valid, "R11 wb_valid after reset", 32'(wb_valid), 32'd0);
    chk(req_ready, "R11 req_ready after reset", 32'(req_ready), 32'd1);

    // Directed corners.
    do_op(6'd43, 32'h0000_0040, 16'h0000, 32'hDEAD_BEEF, 0);   // R4 aligned word store
    do_op(6'd35, 32'h0000_0044, 16'hFFFC, 32'h0, 0);           // R1 negative offset, R7 load
    for (int k = 0; k < 4; k++)
      do_op(6'd40, 32'h0000_0050, 16'(k), 32'h1234_5600 | 32'(8'h80 + k), 0); // R5 each lane
    do_op(6'd35, 32'h0000_0050, 16'h0000, 32'h0, 0);           // R5 only one byte each
    for (int k = 0; k < 4; k++)
      do_op(6'd32, 32'h0000_0040, 16'(k), 32'h0, 0);           // R6 lanes of DEADBEEF
    do_op(6'd40, 32'h0000_0060, 16'h0001, 32'hFFFF_FF7F, 0);   // positive byte
    do_op(6'd32, 32'h0000_0061, 16'h0000, 32'h0, 0);           // R6 zero fill
    do_op(6'd43, 32'h0000_0040, 16'h0002, 32'h0BAD_F00D, 0);   // R2 misaligned store
    do_op(6'd35, 32'h0000_0040, 16'h0000, 32'h0, 0);           // R2 memory untouched
    do_op(6'd35, 32'h0000_0041, 16'h0000, 32'h0, 0);           // R2 misaligned load
    do_op(6'd32, 32'h0000_0043, 16'h0000, 32'h0, 0);           // R3 odd byte address
    do_op(6'd0,  32'h0000_0040, 16'h0000, 32'hFFFF_FFFF, 0);   // R10 unknown
    do_op(6'd35, 32'h0000_0050, 16'h0000, 32'h0, 3);           // R9 stall
    do_op(6'd43, 32'h0000_0049, 16'h0000, 32'h1, 2);           // R9 stalled misalign

    // Constrained random mix.
    for (int n = 0; n < 400; n++) begin
      logic [5:0] opc;
      logic [15:0] off;
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1: opc = 6'd35;
        2, 3: opc = 6'd43;
        4, 5, 6: opc = 6'd32;
        7, 8: opc = 6'd40;
        default: opc = 6'($urandom);
      endcase
      off = ($urandom_range(0, 1) == 0) ? 16'($urandom) : 16'($urandom_range(0, 7) << (($urandom_range(0, 3) == 0) ? 0 : 2));
      do_op(opc, $urandom, off, $urandom, int'($urandom_range(0, 2)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule